// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block takes a scalar core into its exception handler. In each cycle it receives two things. The first is the state of the instruction fetch: the address about to be fetched and whether the bus rejected it. The second is the state of the instruction now executing: its address, whether it sits in a branch delay slot, its coprocessor-number field, whether it is a coprocessor operation, and any data access it makes. From these, and from the mode and coprocessor-usable bits it holds in its own status register, it decides whether an exception is taken and which code to report.

When an exception is taken, the block does the following:
- drives a combinational flush that kills the instruction already fetched;
- records the exception PC, the cause fields and, for address errors, the faulting address;
- pushes the mode/interrupt-enable stack;
- one cycle later, raises a single-cycle redirect carrying the handler vector.

When no exception is taken, an accepted fetch advances the committed PC. The datapath can load the status register, and a return-from-exception strobe can pop its stack.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset the outputs read as follows: pc 0xBFC0_0000; epc, cause and badvaddr zero; redirect low; status holding only the boot-vector bit (bit 22).
- R2: An execute fault on an instruction that is not in a delay slot writes epc with that instruction's address and clears cause bit 31 (BD).
- R3: An execute fault on an instruction in a branch delay slot writes epc with its address minus 4 and sets cause bit 31.
- R4: Every execute fault copies the instruction's coprocessor-number field into cause bits 29:28. Fetch faults write 0 there.
- R5: On every exception entry, status bits 5:0 (bit 0 current interrupt enable, bit 1 current user mode) shift left by two, with zeros entering bits 1:0.
- R6: A fetch request to an address whose bits 1:0 are not zero raises code 4 without fetching, even when a bus error is also reported. Both epc and badvaddr receive the fetch address, BD is 0, and pc keeps its value.
- R7: An aligned fetch that meets a bus error raises code 6 with epc set to the fetch address and BD 0. Neither badvaddr nor pc changes.
- R8: A fetch request that raises no exception, in a cycle with no exception, loads pc with the fetch address.
- R9: The access size is coded 0 for byte, 1 for halfword and 2 for word. A halfword access with address bit 0 set, or a word access with either of bits 1:0 set, is misaligned; a byte access never is. A misaligned load raises code 4 and a misaligned store raises code 5, and in both cases badvaddr receives the data address.
- R10: A data bus error on an aligned access raises code 7 and leaves badvaddr unchanged.
- R11: A coprocessor operation raises code 11 in three cases: it targets coprocessor 0 in user mode with the CU0 bit (status bit 28) clear; it targets coprocessor 2 in user mode with the CU2 bit (status bit 30) clear; or it targets coprocessor 3. In kernel mode, coprocessors 0 and 2 never fault.
- R12: An exception drives flush in its own cycle. In the next cycle redirect is high for exactly one cycle, with redirect_pc set to 0xBFC0_0180 if the boot-vector bit is set and 0x8000_0080 otherwise. The exception code sits in cause bits 6:2.
- R13: An execute fault takes priority over a fetch fault in the same cycle. Within one instruction, coprocessor-unusable takes priority over a data address error, and a data address error takes priority over a data bus error.
- R14: With no exception, a return-from-exception strobe copies status bits 5:2 into bits 3:0 and leaves bits 5:4 as they were. Without that strobe, a status write loads bits 5:0, 22, 28 and 30 from the write data. An exception takes precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | A fetch is attempted at fetch_pc this cycle |
| fetch_pc | input | 32 | Address of the next fetch |
| fetch_bus_err | input | 1 | Bus rejected the fetch |
| ex_valid | input | 1 | An instruction is executing |
| ex_pc | input | 32 | Address of the executing instruction |
| ex_in_delay | input | 1 | Executing instruction is in a branch delay slot |
| ex_cop_num | input | 2 | Coprocessor-number field of the instruction |
| ex_is_cop | input | 1 | Instruction is a coprocessor operation or coprocessor load/store |
| ex_mem_rd | input | 1 | Instruction performs a data load |
| ex_mem_wr | input | 1 | Instruction performs a data store |
| ex_mem_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| ex_mem_addr | input | 32 | Data access address |
| ex_dbus_err | input | 1 | Bus rejected the data access |
| sr_wr_en | input | 1 | Load the status register |
| sr_wr_data | input | 32 | Status write data |
| rfe | input | 1 | Return-from-exception: pop the mode stack |
| flush | output | 1 | Exception taken this cycle; discard the fetched instruction |
| redirect | output | 1 | One-cycle jump request to the handler |
| redirect_pc | output | 32 | Handler vector |
| pc | output | 32 | Committed fetch PC |
| epc | output | 32 | Exception PC |
| cause | output | 32 | Code in bits 6:2, coprocessor number in 29:28, BD in 31 |
| badvaddr | output | 32 | Faulting address of the last address error |
| status | output | 32 | Mode stack in 5:0, boot vector in 22, CU0 in 28, CU2 in 30 |

## Verification
The assertions assume three things about the inputs. First, a load and a store are never requested together. Second, the return strobe and a status write stay low in the cycle the checker sees flush. Third, the register values before any exception come only from reset or a status write. The stimulus meets these conditions by construction. Each directed step sets at most one of load or store, and every step starts from an all-idle input set. A step that contains a fault has no status write or return strobe. The checks for simultaneous faults, a misaligned fetch that also reports a bus error, and a coprocessor fault combined with a misaligned access are each placed in a separate step.

// File: rtl/exc_entry_pkg.sv
// Shared types and field positions for the exception entry controller.
// Assumes a 32-bit address space and the cause/status layout given in the brief.
package exc_entry_pkg;
    localparam int ADDR_W   = 32;
    localparam int CODE_W   = 5;
    localparam int COPN_W   = 2;
    localparam int STACK_W  = 6;
    localparam int SR_BEV   = 22;
    localparam int SR_CU0   = 28;
    localparam int SR_CU2   = 30;
    localparam int CA_CODE  = 2;
    localparam int CA_CE    = 28;
    localparam int CA_BD    = 31;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [CODE_W-1:0] {
        EC_NONE      = 5'd0,
        EC_ADDR_LD   = 5'd4,
        EC_ADDR_ST   = 5'd5,
        EC_IBUS      = 5'd6,
        EC_DBUS      = 5'd7,
        EC_COP_UNUSE = 5'd11
    } exc_code_e;

    typedef struct packed {
        logic              take;
        exc_code_e         code;
        logic [ADDR_W-1:0] epc;
        logic              bd;
        logic [COPN_W-1:0] ce;
        logic              set_bad;
        logic [ADDR_W-1:0] bad;
    } exc_req_t;
endpackage

// File: rtl/exc_align_check.sv
// Alignment test for one access. Looks only at the low address bits.
// Assumes a size code outside byte/half/word never faults.
module exc_align_check
    import exc_entry_pkg::*;
#(
    parameter int LSB_W = 2
) (
    input  logic [LSB_W-1:0] addr_lsb,
    input  acc_size_e        size,
    output logic             misaligned
);
    // Decide misalignment from the size and the low address bits.
    always_comb begin
        case (size)
            ACC_HALF: misaligned = addr_lsb[0];
            ACC_WORD: misaligned = |addr_lsb[1:0];
            default:  misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_fault_sel.sv
// Priority selection of one exception per cycle.
// Execute faults beat fetch faults. Within an instruction, coprocessor-unusable
// beats data misalignment, which beats a data bus error.
// Assumes at most one of ex_mem_rd / ex_mem_wr is high.
module exc_fault_sel
    import exc_entry_pkg::*;
(
    input  logic              ex_valid,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic              ex_in_delay,
    input  logic [COPN_W-1:0] ex_cop_num,
    input  logic              ex_is_cop,
    input  logic              ex_mem_rd,
    input  logic              ex_mem_wr,
    input  logic [ADDR_W-1:0] ex_mem_addr,
    input  logic              ex_data_mis,
    input  logic              ex_dbus_err,
    input  logic              user_mode,
    input  logic              cu0,
    input  logic              cu2,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_mis,
    input  logic              fetch_bus_err,
    output exc_req_t          req
);
    logic cop_block;
    logic mem_act;
    logic ex_fault;
    logic fetch_fault;

    // Coprocessor usability check against mode and usable bits.
    always_comb begin
        cop_block = 1'b0;
        if (ex_is_cop) begin
            case (ex_cop_num)
                2'd0:    cop_block = user_mode && !cu0;
                2'd2:    cop_block = user_mode && !cu2;
                2'd3:    cop_block = 1'b1;
                default: cop_block = 1'b0;
            endcase
        end
    end

    assign mem_act     = ex_mem_rd || ex_mem_wr;
    assign ex_fault    = ex_valid && (cop_block || (mem_act && (ex_data_mis || ex_dbus_err)));
    assign fetch_fault = fetch_req && (fetch_mis || fetch_bus_err);

    // Build the selected exception record.
    always_comb begin
        req = '0;
        if (ex_fault) begin
            req.take = 1'b1;
            req.bd   = ex_in_delay;
            req.epc  = ex_in_delay ? (ex_pc - ADDR_W'(4)) : ex_pc;
            req.ce   = ex_cop_num;
            if (cop_block) begin
                req.code = EC_COP_UNUSE;
            end else if (ex_data_mis) begin
                req.code    = ex_mem_wr ? EC_ADDR_ST : EC_ADDR_LD;
                req.set_bad = 1'b1;
                req.bad     = ex_mem_addr;
            end else begin
                req.code = EC_DBUS;
            end
        end else if (fetch_fault) begin
            req.take = 1'b1;
            req.epc  = fetch_pc;
            if (fetch_mis) begin
                req.code    = EC_ADDR_LD;
                req.set_bad = 1'b1;
                req.bad     = fetch_pc;
            end else begin
                req.code = EC_IBUS;
            end
        end
    end
endmodule

// File: rtl/exc_cop_regs.sv
// System-control state: pc, epc, cause, badvaddr, status and the redirect.
// An exception outranks the return strobe, which outranks a status write.
module exc_cop_regs
    import exc_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET   = 32'hBFC0_0000,
    parameter logic [ADDR_W-1:0] VEC_NORMAL = 32'h8000_0080,
    parameter logic [ADDR_W-1:0] VEC_BOOT   = 32'hBFC0_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  exc_req_t          req,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              sr_wr_en,
    input  logic [ADDR_W-1:0] sr_wr_data,
    input  logic              rfe,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] epc,
    output logic [ADDR_W-1:0] cause,
    output logic [ADDR_W-1:0] badvaddr,
    output logic [ADDR_W-1:0] status
);
    logic [STACK_W-1:0] stack;
    logic               bev, cu0, cu2;
    exc_code_e          code_q;
    logic [COPN_W-1:0]  ce_q;
    logic               bd_q;

    // Register update on exception, fetch, return strobe or status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
            pc          <= PC_RESET;
            epc         <= '0;
            badvaddr    <= '0;
            code_q      <= EC_NONE;
            ce_q        <= '0;
            bd_q        <= 1'b0;
            stack       <= '0;
            bev         <= 1'b1;
            cu0         <= 1'b0;
            cu2         <= 1'b0;
        end else begin
            redirect <= req.take;
            if (req.take) begin
                epc         <= req.epc;
                code_q      <= req.code;
                ce_q        <= req.ce;
                bd_q        <= req.bd;
                stack       <= {stack[STACK_W-3:0], 2'b00};
                redirect_pc <= bev ? VEC_BOOT : VEC_NORMAL;
                if (req.set_bad) badvaddr <= req.bad;
            end else begin
                if (fetch_req) pc <= fetch_pc;
                if (rfe) begin
                    stack[STACK_W-3:0] <= stack[STACK_W-1:2];
                end else if (sr_wr_en) begin
                    stack <= sr_wr_data[STACK_W-1:0];
                    bev   <= sr_wr_data[SR_BEV];
                    cu0   <= sr_wr_data[SR_CU0];
                    cu2   <= sr_wr_data[SR_CU2];
                end
            end
        end
    end

    // Assemble the architectural views of cause and status.
    always_comb begin
        cause = '0;
        cause[CA_CODE +: CODE_W] = code_q;
        cause[CA_CE +: COPN_W]   = ce_q;
        cause[CA_BD]             = bd_q;
        status = '0;
        status[STACK_W-1:0] = stack;
        status[SR_BEV]      = bev;
        status[SR_CU0]      = cu0;
        status[SR_CU2]      = cu2;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception entry controller: alignment checks, fault priority
// and system-control state. flush is combinational in the fault cycle;
// redirect follows one cycle later.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PC_RESET   = 32'hBFC0_0000,
    parameter logic [ADDR_W-1:0] VEC_NORMAL = 32'h8000_0080,
    parameter logic [ADDR_W-1:0] VEC_BOOT   = 32'hBFC0_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_bus_err,
    input  logic              ex_valid,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic              ex_in_delay,
    input  logic [COPN_W-1:0] ex_cop_num,
    input  logic              ex_is_cop,
    input  logic              ex_mem_rd,
    input  logic              ex_mem_wr,
    input  logic [1:0]        ex_mem_size,
    input  logic [ADDR_W-1:0] ex_mem_addr,
    input  logic              ex_dbus_err,
    input  logic              sr_wr_en,
    input  logic [ADDR_W-1:0] sr_wr_data,
    input  logic              rfe,
    output logic              flush,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] epc,
    output logic [ADDR_W-1:0] cause,
    output logic [ADDR_W-1:0] badvaddr,
    output logic [ADDR_W-1:0] status
);
    localparam int LSB_W = 2;

    logic     fetch_mis;
    logic     data_mis;
    exc_req_t req;

    exc_align_check #(.LSB_W(LSB_W)) u_fetch_align (
        .addr_lsb   (fetch_pc[LSB_W-1:0]),
        .size       (ACC_WORD),
        .misaligned (fetch_mis)
    );

    exc_align_check #(.LSB_W(LSB_W)) u_data_align (
        .addr_lsb   (ex_mem_addr[LSB_W-1:0]),
        .size       (acc_size_e'(ex_mem_size)),
        .misaligned (data_mis)
    );

    exc_fault_sel u_sel (
        .ex_valid      (ex_valid),
        .ex_pc         (ex_pc),
        .ex_in_delay   (ex_in_delay),
        .ex_cop_num    (ex_cop_num),
        .ex_is_cop     (ex_is_cop),
        .ex_mem_rd     (ex_mem_rd),
        .ex_mem_wr     (ex_mem_wr),
        .ex_mem_addr   (ex_mem_addr),
        .ex_data_mis   (data_mis),
        .ex_dbus_err   (ex_dbus_err),
        .user_mode     (status[1]),
        .cu0           (status[SR_CU0]),
        .cu2           (status[SR_CU2]),
        .fetch_req     (fetch_req),
        .fetch_pc      (fetch_pc),
        .fetch_mis     (fetch_mis),
        .fetch_bus_err (fetch_bus_err),
        .req           (req)
    );

    exc_cop_regs #(
        .PC_RESET   (PC_RESET),
        .VEC_NORMAL (VEC_NORMAL),
        .VEC_BOOT   (VEC_BOOT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .fetch_req   (fetch_req),
        .fetch_pc    (fetch_pc),
        .sr_wr_en    (sr_wr_en),
        .sr_wr_data  (sr_wr_data),
        .rfe         (rfe),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .pc          (pc),
        .epc         (epc),
        .cause       (cause),
        .badvaddr    (badvaddr),
        .status      (status)
    );

    assign flush = req.take;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Port-level properties of the exception entry controller, bound to the top.
module exc_entry_ctrl_chk #(
    parameter logic [31:0] VEC_NORMAL = 32'h8000_0080,
    parameter logic [31:0] VEC_BOOT   = 32'hBFC0_0180
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        redirect,
    input logic [31:0] redirect_pc,
    input logic        fetch_req,
    input logic [31:0] fetch_pc,
    input logic [31:0] pc,
    input logic [31:0] cause,
    input logic [31:0] badvaddr,
    input logic [31:0] status
);
    assert_flush_then_redirect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> redirect);

    assert_redirect_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !flush) |=> !redirect);

    assert_vector_by_bev_R12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (redirect_pc == (status[22] ? VEC_BOOT : VEC_NORMAL)));

    assert_stack_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (status[5:0] == {$past(status[3:0]), 2'b00}));

    assert_pc_hold_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(pc));

    assert_pc_follows_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !flush) |=> (pc == $past(fetch_pc)));

    assert_bus_err_keeps_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && (cause[6:2] == 5'd6 || cause[6:2] == 5'd7)) |-> $stable(badvaddr));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
    .VEC_NORMAL (VEC_NORMAL),
    .VEC_BOOT   (VEC_BOOT)
) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req, fetch_bus_err, ex_valid, ex_in_delay, ex_is_cop;
    logic        ex_mem_rd, ex_mem_wr, ex_dbus_err, sr_wr_en, rfe;
    logic [31:0] fetch_pc, ex_pc, ex_mem_addr, sr_wr_data;
    logic [1:0]  ex_cop_num, ex_mem_size;
    logic        flush, redirect;
    logic [31:0] redirect_pc, pc, epc, cause, badvaddr, status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_pc, m_epc, m_bad, m_sr, m_rpc;
    int          m_code, m_ce;
    bit          m_bd, m_redir;

    always #(HALF) clk = ~clk;

    exc_entry_ctrl u_dut (.*);

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        fetch_req = 0; fetch_bus_err = 0; fetch_pc = 0;
        ex_valid = 0; ex_pc = 0; ex_in_delay = 0; ex_cop_num = 0; ex_is_cop = 0;
        ex_mem_rd = 0; ex_mem_wr = 0; ex_mem_size = 0; ex_mem_addr = 0; ex_dbus_err = 0;
        sr_wr_en = 0; sr_wr_data = 0; rfe = 0;
    endtask

    task automatic check_regs(input string tag);
        cmp(tag, "pc", pc, m_pc);
        cmp(tag, "epc", epc, m_epc);
        cmp(tag, "badvaddr", badvaddr, m_bad);
        cmp(tag, "status", status, m_sr);
        cmp(tag, "cause", cause, {m_bd, 1'b0, 2'(m_ce), 21'd0, 5'(m_code), 2'b00});
        cmp(tag, "redirect", {31'd0, redirect}, {31'd0, m_redir});
        if (m_redir) cmp(tag, "redirect_pc", redirect_pc, m_rpc);
    endtask

    // One clock: predict, compare flush, advance, compare registers.
    task automatic step(input string tag);
        bit user, copfault, dmis, fmis, exf, ff, take;
        int code;
        logic [31:0] e, b;
        bit bd, setb;
        int ce;
        #1;
        user = m_sr[1];
        copfault = 0;
        if (ex_is_cop) begin
            if (ex_cop_num == 3) copfault = 1;
            else if (ex_cop_num == 0 && user && !m_sr[28]) copfault = 1;
            else if (ex_cop_num == 2 && user && !m_sr[30]) copfault = 1;
        end
        dmis = (ex_mem_size == 1 && (ex_mem_addr % 2) != 0) || (ex_mem_size == 2 && (ex_mem_addr % 4) != 0);
        fmis = (fetch_pc % 4) != 0;
        exf = ex_valid && (copfault || ((ex_mem_rd || ex_mem_wr) && (dmis || ex_dbus_err)));
        ff = fetch_req && (fmis || fetch_bus_err);
        take = exf || ff;
        code = 0; e = 0; b = 0; bd = 0; setb = 0; ce = 0;
        if (exf) begin
            bd = ex_in_delay;
            e = bd ? ex_pc - 4 : ex_pc;
            ce = ex_cop_num;
            if (copfault) code = 11;
            else if (dmis) begin code = ex_mem_wr ? 5 : 4; setb = 1; b = ex_mem_addr; end
            else code = 7;
        end else if (ff) begin
            e = fetch_pc;
            if (fmis) begin code = 4; setb = 1; b = fetch_pc; end
            else code = 6;
        end
        cmp(tag, "flush", {31'd0, flush}, {31'd0, take});
        @(posedge clk);
        m_redir = take;
        if (take) begin
            m_rpc = m_sr[22] ? 32'hBFC0_0180 : 32'h8000_0080;
            m_epc = e; m_code = code; m_bd = bd; m_ce = ce;
            if (setb) m_bad = b;
            m_sr[5:0] = {m_sr[3:0], 2'b00};
        end else begin
            if (fetch_req) m_pc = fetch_pc;
            if (rfe) m_sr[3:0] = m_sr[5:2];
            else if (sr_wr_en) m_sr = sr_wr_data & 32'h5040_003F;
        end
        @(negedge clk);
        check_regs(tag);
        idle();
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_pc = 32'hBFC0_0000; m_epc = 0; m_bad = 0; m_sr = 32'h0040_0000; m_rpc = 0;
        m_code = 0; m_ce = 0; m_bd = 0; m_redir = 0;
        check_regs("R1");

        // R8: plain fetches advance pc
        fetch_req = 1; fetch_pc = 32'hBFC0_0004; step("R8");
        fetch_req = 1; fetch_pc = 32'hBFC0_0008; step("R8");

        // R14: status write into user mode, interrupts on, BEV off
        sr_wr_en = 1; sr_wr_data = 32'hFFFF_FF03 & ~32'h5040_0000; step("R14");
        // R11 R2 R4 R5: cop0 in user mode without CU0, not in delay slot
        ex_valid = 1; ex_pc = 32'h0000_1000; ex_is_cop = 1; ex_cop_num = 0; step("R11");
        step("R12");
        // R11: cop0 in kernel mode, no fault
        ex_valid = 1; ex_pc = 32'h0000_1004; ex_is_cop = 1; ex_cop_num = 0; step("R11");
        // R14: user mode with CU2 set
        sr_wr_en = 1; sr_wr_data = 32'h4000_0003; step("R14");
        ex_valid = 1; ex_pc = 32'h0000_1008; ex_is_cop = 1; ex_cop_num = 2; step("R11");
        // R3 R4: cop3 in delay slot
        ex_valid = 1; ex_pc = 32'h0000_2004; ex_is_cop = 1; ex_cop_num = 3; ex_in_delay = 1; step("R3");
        step("R12");
        // R14: return pops the stack
        rfe = 1; step("R14");
        // R11: cop2 user without CU2
        sr_wr_en = 1; sr_wr_data = 32'h0000_0002; step("R14");
        ex_valid = 1; ex_pc = 32'h0000_3000; ex_is_cop = 1; ex_cop_num = 2; step("R11");
        // R9: misaligned word load, half store, aligned half, byte
        ex_valid = 1; ex_pc = 32'h0000_3010; ex_mem_rd = 1; ex_mem_size = 2; ex_mem_addr = 32'h0000_1002; step("R9");
        ex_valid = 1; ex_pc = 32'h0000_3014; ex_mem_wr = 1; ex_mem_size = 1; ex_mem_addr = 32'h0000_1001; step("R9");
        ex_valid = 1; ex_pc = 32'h0000_3018; ex_mem_rd = 1; ex_mem_size = 1; ex_mem_addr = 32'h0000_1002; step("R9");
        ex_valid = 1; ex_pc = 32'h0000_301C; ex_mem_wr = 1; ex_mem_size = 0; ex_mem_addr = 32'h0000_1003; step("R9");
        // R10: data bus error on aligned word
        ex_valid = 1; ex_pc = 32'h0000_3020; ex_mem_rd = 1; ex_mem_size = 2; ex_mem_addr = 32'h0000_2000; ex_dbus_err = 1; step("R10");
        // R6: misaligned fetch, also with bus error
        fetch_req = 1; fetch_pc = 32'h8000_0102; step("R6");
        fetch_req = 1; fetch_pc = 32'h8000_0201; fetch_bus_err = 1; step("R6");
        // R7: aligned fetch bus error
        fetch_req = 1; fetch_pc = 32'h8000_0300; fetch_bus_err = 1; step("R7");
        // R13: execute fault beats fetch fault
        fetch_req = 1; fetch_pc = 32'h8000_0402; ex_valid = 1; ex_pc = 32'h0000_4000;
        ex_mem_wr = 1; ex_mem_size = 2; ex_mem_addr = 32'h0000_5006; step("R13");
        // R13: cop fault beats misaligned access (cop2 store, user, no CU2)
        sr_wr_en = 1; sr_wr_data = 32'h0000_0002; step("R14");
        ex_valid = 1; ex_pc = 32'h0000_4100; ex_is_cop = 1; ex_cop_num = 2;
        ex_mem_wr = 1; ex_mem_size = 2; ex_mem_addr = 32'h0000_6001; step("R13");
        // R13: misalignment beats data bus error
        ex_valid = 1; ex_pc = 32'h0000_4200; ex_mem_rd = 1; ex_mem_size = 1; ex_mem_addr = 32'h0000_7001; ex_dbus_err = 1; step("R13");
        // R12: boot vector when BEV set
        sr_wr_en = 1; sr_wr_data = 32'h0040_0000; step("R14");
        fetch_req = 1; fetch_pc = 32'h8000_0503; step("R12");
        step("R12");
        fetch_req = 1; fetch_pc = 32'h8000_0600; step("R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule